// File: doc/BRIEF.md
# Multi-Lane Readout Word Serializer

This block turns hit records into framed 24-bit words and sends them over one, two, four or six serial lanes. Each lane carries two bits per readout-clock cycle, one for each clock edge. A hit record comes from the core logic over a valid/ready handshake in the readout-clock domain. It holds a 4-bit strip number, a 5-bit logic-set number and an 8-bit crossing timestamp. The block has no output queue. It takes a record only at a word boundary, and the record becomes the next word on the lanes.

When no record is offered at a boundary, the block sends a sync/status word instead. That word carries a 10-bit status value, sampled at the boundary, and a fixed 13-bit synchronization pattern, so the lanes always carry framed words. The first bit of every word is a mark that tells the two kinds apart. The lane count is also taken at the boundary and stays fixed for the whole word. Words leave in acceptance order, and nothing is reordered by timestamp.

Top module: `readout_word_serializer`

## Requirements
- R1: While `rst_n` is low, `lane_data`, `lane_en`, `word_start` and `hit_ready` are all 0. In the cycle in which `rst_n` is first high, `hit_ready` is 1, and the first word starts on the next cycle.
- R2: A data word, indexed in send order with bit 0 sent first, is laid out as follows: bit 0 is the mark, equal to 1; bits 4:1 hold the strip; bits 9:5 hold the logic set; bits 17:10 hold the timestamp; bits 23:18 are 0. Each field is sent LSB first.
- R3: A sync/status word has mark bit 0 equal to 0. Bits 10:1 hold the status value and bits 23:11 hold the sync pattern 13'h15A3.
- R4: With N active lanes, word bit i goes to lane i mod N. In cycle c of a word, lane k sends bit 2cN+k on `lane_data[2k]` (first edge) and bit 2cN+N+k on `lane_data[2k+1]` (second edge). The data bits of inactive lanes are 0.
- R5: `lane_sel` codes 0, 1, 2 and 3 select 1, 2, 4 and 6 lanes. A word then lasts 12, 6, 3 or 2 cycles, and `hit_ready` is 1 only in the last cycle of a word.
- R6: A record offered while `hit_valid` and `hit_ready` are both high is sent as the very next word. A record offered while `hit_ready` is low is not taken, and the word in progress runs to its end unchanged.
- R7: If `hit_valid` is low in the boundary cycle, the next word is a sync/status word. Its status field is `status_in` as it stood in that cycle; later changes to `status_in` do not affect it.
- R8: `lane_sel` is sampled only in the boundary cycle. A change in mid-word does not affect the word in progress.
- R9: `word_start` is 1 in the first cycle of each word and 0 in every other cycle.
- R10: `lane_en` is a mask of the active lanes: 6'h01, 6'h03, 6'h0F or 6'h3F for codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_sel | input | 2 | Lane count code, sampled at word boundaries |
| status_in | input | 10 | Status value for sync/status words |
| hit_valid | input | 1 | Hit record offered |
| hit_ready | output | 1 | Record taken at this edge (word boundary) |
| hit_strip | input | 4 | Strip number |
| hit_set | input | 5 | Logic-set number |
| hit_bco | input | 8 | Crossing timestamp |
| lane_data | output | 12 | Two bits per lane: [2k] first edge, [2k+1] second edge |
| lane_en | output | 6 | Active lane mask |
| word_start | output | 1 | First cycle of a word |

## Verification
Taking a record and switching the lane count can both happen on the same boundary edge. The bench provokes this by changing `lane_sel` in the middle of a one-lane data word while the next record waits. It then decodes the first word with the one-lane mapping over 12 cycles and the second word with the six-lane mapping over 2 cycles. Both words must match their expected layout exactly. A record raised in the middle of a sync word is checked the same way: the sync word must end intact, and the record must follow it as the next word.

// File: rtl/readout_word_serializer.sv
module readout_word_serializer #(
  parameter int STRIP_W  = 4,
  parameter int SET_W    = 5,
  parameter int BCO_W    = 8,
  parameter int STATUS_W = 10,
  parameter int SYNC_W   = 13,
  parameter logic [SYNC_W-1:0] SYNC_PATTERN = 13'h15A3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           lane_sel,
  input  logic [STATUS_W-1:0]  status_in,
  input  logic                 hit_valid,
  output logic                 hit_ready,
  input  logic [STRIP_W-1:0]   hit_strip,
  input  logic [SET_W-1:0]     hit_set,
  input  logic [BCO_W-1:0]     hit_bco,
  output logic [11:0]          lane_data,
  output logic [5:0]           lane_en,
  output logic                 word_start
);
  localparam int WORD_W    = 1 + STATUS_W + SYNC_W;
  localparam int MAX_LANES = 6;
  localparam int CW        = $clog2(WORD_W / 2 + 1);

  function automatic int lanes_of(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return MAX_LANES;
    endcase
  endfunction

  logic [WORD_W-1:0] sh;
  logic [1:0]        mode;
  logic [CW-1:0]     cnt;
  logic              live;
  logic              wstart;
  logic [WORD_W-1:0] hit_word, sync_word;

  assign hit_word   = WORD_W'({hit_bco, hit_set, hit_strip, 1'b1});
  assign sync_word  = {SYNC_PATTERN, status_in, 1'b0};
  assign hit_ready  = rst_n && (cnt == '0);
  assign word_start = wstart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      mode   <= 2'd0;
      cnt    <= '0;
      live   <= 1'b0;
      wstart <= 1'b0;
    end else if (cnt == '0) begin
      sh     <= hit_valid ? hit_word : sync_word;
      mode   <= lane_sel;
      cnt    <= CW'(WORD_W / (2 * lanes_of(lane_sel)) - 1);
      live   <= 1'b1;
      wstart <= 1'b1;
    end else begin
      sh     <= sh >> (2 * lanes_of(mode));
      cnt    <= cnt - 1'b1;
      wstart <= 1'b0;
    end
  end

  always_comb begin
    lane_data = '0;
    lane_en   = '0;
    if (live) begin
      for (int k = 0; k < MAX_LANES; k++) begin
        if (k < lanes_of(mode)) begin
          lane_data[2*k]   = sh[k];
          lane_data[2*k+1] = sh[lanes_of(mode) + k];
          lane_en[k]       = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/readout_word_serializer_chk.sv
module readout_word_serializer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hit_valid,
  input logic        hit_ready,
  input logic [11:0] lane_data,
  input logic [5:0]  lane_en,
  input logic        word_start
);
  logic [11:0] pair_mask;
  always_comb begin
    for (int k = 0; k < 6; k++) begin
      pair_mask[2*k]   = lane_en[k];
      pair_mask[2*k+1] = lane_en[k];
    end
  end

  p_start_follows_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ready |=> word_start);

  p_start_not_on_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_start && hit_ready));

  p_taken_hit_marked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_ready) |=> lane_data[0]);

  p_idle_sends_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_valid && hit_ready) |=> !lane_data[0]);

  p_idle_lanes_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_data & ~pair_mask) == 12'h000);

  p_lane_mask_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> (lane_en == 6'h01 || lane_en == 6'h03 ||
                    lane_en == 6'h0F || lane_en == 6'h3F));

  p_mode_held_midword_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ready |=> $stable(lane_en));
endmodule

bind readout_word_serializer readout_word_serializer_chk u_chk (.*);

// File: tb/tb_readout_word_serializer.sv
module tb_readout_word_serializer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  lane_sel;
  logic [9:0]  status_in;
  logic        hit_valid;
  logic        hit_ready;
  logic [3:0]  hit_strip;
  logic [4:0]  hit_set;
  logic [7:0]  hit_bco;
  logic [11:0] lane_data;
  logic [5:0]  lane_en;
  logic        word_start;

  int vec = 0;
  int bad = 0;

  always #2 clk = ~clk;

  readout_word_serializer dut (
    .clk(clk), .rst_n(rst_n), .lane_sel(lane_sel), .status_in(status_in),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_strip(hit_strip),
    .hit_set(hit_set), .hit_bco(hit_bco), .lane_data(lane_data),
    .lane_en(lane_en), .word_start(word_start)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int nl(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic logic [23:0] dword(input logic [3:0] s, input logic [4:0] g,
                                        input logic [7:0] b);
    return {6'b0, b, g, s, 1'b1};
  endfunction

  function automatic logic [23:0] sword(input logic [9:0] st);
    return {13'h15A3, st, 1'b0};
  endfunction

  task automatic wait_boundary();
    while (!hit_ready) @(negedge clk);
  endtask

  // Called at the negedge of a word's first cycle; returns at the negedge of its last.
  task automatic recv(input logic [1:0] code, output logic [23:0] w);
    int n = nl(code);
    int cyc = 24 / (2 * n);
    logic [6:0] m = (7'd1 << n) - 7'd1;
    w = '0;
    chk("R9", "word_start first cycle", word_start, 1);
    for (int c = 0; c < cyc; c++) begin
      if (c > 0) begin
        @(negedge clk);
        chk("R9", "word_start later cycle", word_start, 0);
      end
      chk("R10", "lane_en", lane_en, m[5:0]);
      chk("R5", "hit_ready position", hit_ready, (c == cyc - 1));
      for (int k = 0; k < 6; k++) begin
        if (k < n) begin
          w[c*2*n + k]     = lane_data[2*k];
          w[c*2*n + n + k] = lane_data[2*k+1];
        end else begin
          chk("R4", "inactive lane bits", lane_data[2*k +: 2], 0);
        end
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hit_valid = 1'b0; lane_sel = 2'd0; status_in = '0;
    hit_strip = '0; hit_set = '0; hit_bco = '0;
    repeat (3) @(negedge clk);
    chk("R1", "lane_data in reset", lane_data, 0);
    chk("R1", "lane_en in reset", lane_en, 0);
    chk("R1", "word_start in reset", word_start, 0);
    chk("R1", "hit_ready in reset", hit_ready, 0);
    rst_n = 1'b1;
    #1;
    chk("R1", "hit_ready after release", hit_ready, 1);
    @(negedge clk);
    chk("R1", "first word starts", word_start, 1);
  endtask

  task automatic t_sync(input logic [1:0] code, input logic [9:0] st);
    logic [23:0] w;
    hit_valid = 1'b0; lane_sel = code; status_in = st;
    wait_boundary();
    @(negedge clk);
    recv(code, w);
    chk("R3", "sync word layout", w, sword(st));
  endtask

  task automatic t_hit(input logic [1:0] code, input logic [3:0] s,
                       input logic [4:0] g, input logic [7:0] b);
    logic [23:0] w;
    lane_sel = code; hit_strip = s; hit_set = g; hit_bco = b; hit_valid = 1'b1;
    wait_boundary();
    @(negedge clk);
    hit_valid = 1'b0;
    recv(code, w);
    chk("R2", "data word layout", w, dword(s, g, b));
  endtask

  task automatic t_back_to_back();
    logic [23:0] w;
    lane_sel = 2'd2; hit_strip = 4'h3; hit_set = 5'h11; hit_bco = 8'hC4; hit_valid = 1'b1;
    wait_boundary();
    @(negedge clk);
    hit_strip = 4'hE; hit_set = 5'h06; hit_bco = 8'h2B;
    recv(2'd2, w);
    chk("R6", "first of pair", w, dword(4'h3, 5'h11, 8'hC4));
    @(negedge clk);
    hit_valid = 1'b0;
    recv(2'd2, w);
    chk("R6", "second of pair", w, dword(4'hE, 5'h06, 8'h2B));
  endtask

  task automatic t_mode_change();
    logic [23:0] w;
    lane_sel = 2'd0; hit_strip = 4'h9; hit_set = 5'h1A; hit_bco = 8'h5E; hit_valid = 1'b1;
    wait_boundary();
    @(negedge clk);
    hit_strip = 4'h6; hit_set = 5'h03; hit_bco = 8'hF1;
    lane_sel = 2'd3;
    recv(2'd0, w);
    chk("R8", "word under old lane count", w, dword(4'h9, 5'h1A, 8'h5E));
    @(negedge clk);
    hit_valid = 1'b0;
    recv(2'd3, w);
    chk("R8", "next word under new lane count", w, dword(4'h6, 5'h03, 8'hF1));
  endtask

  task automatic t_late_hit();
    logic [23:0] w;
    hit_valid = 1'b0; lane_sel = 2'd1; status_in = 10'h2C7;
    wait_boundary();
    @(negedge clk);
    hit_strip = 4'hA; hit_set = 5'h15; hit_bco = 8'h80; hit_valid = 1'b1;
    recv(2'd1, w);
    chk("R6", "sync word not displaced", w, sword(10'h2C7));
    @(negedge clk);
    hit_valid = 1'b0;
    recv(2'd1, w);
    chk("R6", "held record follows", w, dword(4'hA, 5'h15, 8'h80));
  endtask

  task automatic t_status_hold();
    logic [23:0] w;
    hit_valid = 1'b0; lane_sel = 2'd2; status_in = 10'h155;
    wait_boundary();
    @(negedge clk);
    status_in = 10'h0AA;
    recv(2'd2, w);
    chk("R7", "status sampled at boundary", w, sword(10'h155));
    @(negedge clk);
    recv(2'd2, w);
    chk("R7", "new status in next word", w, sword(10'h0AA));
  endtask

  initial begin
    #(4 * 200000);
    vec++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sync(2'd0, 10'h3FF);
    t_sync(2'd1, 10'h001);
    t_sync(2'd2, 10'h200);
    t_sync(2'd3, 10'h13B);
    t_hit(2'd0, 4'h1, 5'h1F, 8'hA5);
    t_hit(2'd1, 4'hF, 5'h00, 8'h01);
    t_hit(2'd2, 4'h8, 5'h10, 8'h80);
    t_hit(2'd3, 4'h5, 5'h0A, 8'hFF);
    t_back_to_back();
    t_mode_change();
    t_late_hit();
    t_status_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule